// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs complete commands against a serial configuration flash for a host. The host gives a command code, a 24-bit flash offset (or a sector index, or status masks) and a byte count. The block then drives a four-wire SPI link in mode 0, one byte at a time. For each command it frames chip select, sends the opcode and address most significant byte first, and moves the data. It releases chip select only once the final bit has shifted out.

Program commands are split so that no burst crosses a page. Every page burst, sector erase and status write gets a write-enable frame of its own just before it, and a status-polling loop after it. Data bytes are bit-reversed in both directions (bit 0 with bit 7, bit 1 with bit 6, and so on). Opcode, address, status and ID bytes go out as they are.

Program data enters on a valid/ready stream. A byte moves when `wr_valid` and `wr_ready` are both high at a clock edge. While `wr_valid` is low the block waits between bytes with chip select held low and SCLK parked low. Read data leaves on a valid/ready stream. `rd_data` holds steady while `rd_valid` is high until `rd_ready` takes it, and no further SPI byte starts until it is taken.

Top module: `sflash_sequencer`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0, `rd_valid` is 0 and `cmd_ready` is 1.
- R2: SCLK idles low and has a period of CLK_DIV clock cycles. MOSI changes only while SCLK is low and is stable at every rising edge. MISO is sampled on the rising edge. Bytes travel most significant bit first.
- R3: Chip select rises only after all 8 bits of the final byte of a frame have been clocked, and with SCLK low.
- R4: Opcodes: 0x06 write enable, 0x05 read status, 0x03 read, 0x02 page program, 0xD8 sector erase, 0x01 write status, 0xAB read ID. Address commands send three address bytes right after the opcode, most significant first.
- R5: Code 0 (read) sends 0x03 and the offset, then delivers `cmd_len` bytes on the read stream, each bit-reversed, all in one frame. `rd_ready` low stalls the link.
- R6: Code 1 (program) cuts the data into chunks that never cross a PAGE_BYTES boundary. The first chunk is PAGE_BYTES minus (offset mod PAGE_BYTES), capped by the count. Each chunk is one 0x02 frame whose data bytes are the stream bytes bit-reversed, preceded by its own 0x06 frame.
- R7: After each program chunk, sector erase or status write, the block sends one-byte read-status frames (0x05) until status bit 0 reads 0. Only then does it start the next chunk or finish.
- R8: Code 2 (erase) sends 0x06, then 0xD8 with the address `cmd_addr` × SECTOR_BYTES, then polls.
- R9: Code 4 (status update) reads status, forms (status & ~`cmd_addr[15:8]`) | `cmd_addr[7:0]`, sends 0x06, then 0x01 with that byte unreversed, then polls.
- R10: Code 3 returns the status byte unreversed. Code 5 sends 0xAB and three zero bytes, then returns the captured ID byte unreversed.
- R11: `busy` rises the cycle after a command is accepted and falls the cycle after the one-cycle `done` pulse. `cmd_valid` while busy has no effect: no frame and no extra `done`.
- R12: A read or program with `cmd_len` 0, and codes 6 and 7, produce no frame. They pulse `done` two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when idle; command taken when both high |
| cmd_code | input | 3 | 0 read, 1 program, 2 erase, 3 read status, 4 status update, 5 read ID |
| cmd_addr | input | 24 | Flash offset, sector index, or {clear mask, set mask} in bits 15:0 |
| cmd_len | input | LEN_W | Byte count for read and program |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Block takes a program byte |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read/status/ID byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read/status/ID byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
`busy` is due one cycle after acceptance. For commands with no frame, `done` is due two cycles after acceptance and `busy` falls one cycle after that. The bench samples these on the falling clock edges that follow those exact rising edges. Each SPI byte lasts 8×CLK_DIV cycles, and a flash model sees every frame only at chip-select release. The scoreboard therefore compares frames when chip select rises and compares stream bytes at each handshake, rather than at fixed cycle numbers. Queues left non-empty after `done` count as failures.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam logic [2:0] CMD_READ = 3'd0;
  localparam logic [2:0] CMD_PROG = 3'd1;
  localparam logic [2:0] CMD_ERASE = 3'd2;
  localparam logic [2:0] CMD_RDSR = 3'd3;
  localparam logic [2:0] CMD_WRSR = 3'd4;
  localparam logic [2:0] CMD_RDID = 3'd5;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_SERASE = 8'hD8;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_RDID = 8'hAB;

  // data phase flavour of one chip-select frame
  typedef enum logic [2:0] {DK_NONE, DK_RX, DK_TX, DK_SIN, DK_SOUT} dkind_t;
  // command progression
  typedef enum logic [2:0] {ST_RMW, ST_WREN, ST_MAIN, ST_POLL, ST_FIN} step_t;

  function automatic logic [7:0] bit_rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/sflash_spi_byte.sv
module sflash_spi_byte #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       idle
);
  localparam int LO = CLK_DIV / 2;
  localparam int HI = CLK_DIV - LO;
  localparam int CW = $clog2(CLK_DIV) + 1;

  logic          active;
  logic          sclk_q;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [7:0]    rx;
  logic          done_q;
  logic          last_ph;

  assign last_ph = sclk_q ? (cnt == CW'(HI - 1)) : (cnt == CW'(LO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh     <= tx_byte;
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (last_ph) begin
        cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx     <= {rx[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = sh[7];
  assign rx_byte   = rx;
  assign byte_done = done_q;
  assign idle      = !active;

  // R2
  mosi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi));
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi));
endmodule

// File: rtl/sflash_chunk.sv
module sflash_chunk #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PG_W      = $clog2(PAGE_BYTES)
) (
  input  logic [PG_W-1:0]  page_off,
  input  logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] chunk
);
  logic [LEN_W:0] room;

  always_comb begin
    room  = (LEN_W+1)'(PAGE_BYTES) - (LEN_W+1)'(page_off);
    chunk = ({1'b0, remain} < room) ? remain : room[LEN_W-1:0];
  end
endmodule

// File: rtl/sflash_sequencer.sv
module sflash_sequencer
  import sflash_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 65536,
  parameter int LEN_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_code,
  input  logic [23:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int PG_W    = $clog2(PAGE_BYTES);
  localparam int SECT_SH = $clog2(SECTOR_BYTES);

  typedef enum logic [2:0] {F_IDLE, F_PLAN, F_LOAD, F_SHIFT, F_HOLD, F_CSOFF, F_FIN} fsm_t;

  fsm_t             fsm;
  step_t            step;
  logic [2:0]       code_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] remain_q;
  logic [7:0]       set_q, clr_q, stat_q, rd_q;
  logic [7:0]       f_op;
  logic [2:0]       f_hdr;
  dkind_t           f_kind;
  logic             f_rev;
  logic [LEN_W-1:0] f_dcnt;
  logic [2:0]       bi;
  logic             cs_n_q;

  logic             eng_start, eng_done, eng_idle;
  logic [7:0]       eng_tx, eng_rx;
  logic [LEN_W-1:0] chunk;
  logic             hdr_phase, data_phase, wr_ready_c;

  sflash_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(eng_rx),
    .byte_done(eng_done), .idle(eng_idle)
  );

  sflash_chunk #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .page_off(addr_q[PG_W-1:0]), .remain(remain_q), .chunk(chunk)
  );

  assign hdr_phase  = (bi <= f_hdr);
  assign data_phase = !hdr_phase && (f_dcnt != '0);

  always_comb begin
    eng_start  = 1'b0;
    eng_tx     = 8'h00;
    wr_ready_c = 1'b0;
    if (fsm == F_LOAD) begin
      if (bi == 3'd0) begin
        eng_start = 1'b1;
        eng_tx    = f_op;
      end else if (hdr_phase) begin
        eng_start = 1'b1;
        case (bi)
          3'd1:    eng_tx = addr_q[23:16];
          3'd2:    eng_tx = addr_q[15:8];
          default: eng_tx = addr_q[7:0];
        endcase
      end else if (data_phase) begin
        case (f_kind)
          DK_TX: begin
            wr_ready_c = 1'b1;
            eng_start  = wr_valid;
            eng_tx     = bit_rev(wr_data);
          end
          DK_SOUT: begin
            eng_start = 1'b1;
            eng_tx    = stat_q;
          end
          default: eng_start = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm      <= F_IDLE;
      step     <= ST_FIN;
      code_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      set_q    <= '0;
      clr_q    <= '0;
      stat_q   <= '0;
      rd_q     <= '0;
      f_op     <= '0;
      f_hdr    <= '0;
      f_kind   <= DK_NONE;
      f_rev    <= 1'b0;
      f_dcnt   <= '0;
      bi       <= '0;
      cs_n_q   <= 1'b1;
    end else begin
      case (fsm)
        F_IDLE: if (cmd_valid) begin
          code_q   <= cmd_code;
          remain_q <= cmd_len;
          set_q    <= cmd_addr[7:0];
          clr_q    <= cmd_addr[15:8];
          addr_q   <= (cmd_code == CMD_ERASE) ? 24'(cmd_addr << SECT_SH) :
                      (cmd_code == CMD_RDID)  ? 24'h0 : cmd_addr;
          case (cmd_code)
            CMD_READ:  step <= (cmd_len == '0) ? ST_FIN : ST_MAIN;
            CMD_PROG:  step <= (cmd_len == '0) ? ST_FIN : ST_WREN;
            CMD_ERASE: step <= ST_WREN;
            CMD_RDSR, CMD_RDID: step <= ST_MAIN;
            CMD_WRSR:  step <= ST_RMW;
            default:   step <= ST_FIN;
          endcase
          fsm <= F_PLAN;
        end
        F_PLAN: begin
          bi     <= '0;
          f_hdr  <= 3'd0;
          f_kind <= DK_NONE;
          f_rev  <= 1'b0;
          f_dcnt <= '0;
          if (step == ST_FIN) begin
            fsm <= F_FIN;
          end else begin
            cs_n_q <= 1'b0;
            fsm    <= F_LOAD;
            case (step)
              ST_WREN: f_op <= OPC_WREN;
              ST_MAIN: begin
                case (code_q)
                  CMD_READ: begin
                    f_op <= OPC_READ; f_hdr <= 3'd3; f_kind <= DK_RX;
                    f_rev <= 1'b1; f_dcnt <= remain_q;
                  end
                  CMD_PROG: begin
                    f_op <= OPC_PROG; f_hdr <= 3'd3; f_kind <= DK_TX; f_dcnt <= chunk;
                  end
                  CMD_ERASE: begin
                    f_op <= OPC_SERASE; f_hdr <= 3'd3;
                  end
                  CMD_WRSR: begin
                    f_op <= OPC_WRSR; f_kind <= DK_SOUT; f_dcnt <= LEN_W'(1);
                  end
                  CMD_RDID: begin
                    f_op <= OPC_RDID; f_hdr <= 3'd3; f_kind <= DK_RX; f_dcnt <= LEN_W'(1);
                  end
                  default: begin
                    f_op <= OPC_RDSR; f_kind <= DK_RX; f_dcnt <= LEN_W'(1);
                  end
                endcase
              end
              default: begin
                f_op <= OPC_RDSR; f_kind <= DK_SIN; f_dcnt <= LEN_W'(1);
              end
            endcase
          end
        end
        F_LOAD: begin
          if (!hdr_phase && f_dcnt == '0) begin
            cs_n_q <= 1'b1;
            fsm    <= F_CSOFF;
          end else if (eng_start) begin
            fsm <= F_SHIFT;
            if (!hdr_phase && f_kind == DK_TX) begin
              addr_q   <= addr_q + 24'd1;
              remain_q <= remain_q - LEN_W'(1);
            end
          end
        end
        F_SHIFT: if (eng_done) begin
          if (bi < 3'd4) bi <= bi + 3'd1;
          fsm <= F_LOAD;
          if (!hdr_phase) begin
            f_dcnt <= f_dcnt - LEN_W'(1);
            if (f_kind == DK_SIN) stat_q <= eng_rx;
            if (f_kind == DK_RX) begin
              rd_q <= f_rev ? bit_rev(eng_rx) : eng_rx;
              fsm  <= F_HOLD;
            end
          end
        end
        F_HOLD: if (rd_ready) fsm <= F_LOAD;
        F_CSOFF: begin
          fsm <= F_PLAN;
          case (step)
            ST_RMW: begin
              stat_q <= (stat_q & ~clr_q) | set_q;
              step   <= ST_WREN;
            end
            ST_WREN: step <= ST_MAIN;
            ST_MAIN: step <= (code_q == CMD_PROG || code_q == CMD_ERASE ||
                              code_q == CMD_WRSR) ? ST_POLL : ST_FIN;
            ST_POLL: begin
              if (stat_q[0])                                step <= ST_POLL;
              else if (code_q == CMD_PROG && remain_q != '0) step <= ST_WREN;
              else                                          step <= ST_FIN;
            end
            default: step <= ST_FIN;
          endcase
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assign cmd_ready = (fsm == F_IDLE);
  assign busy      = (fsm != F_IDLE);
  assign done      = (fsm == F_FIN);
  assign rd_valid  = (fsm == F_HOLD);
  assign rd_data   = rd_q;
  assign wr_ready  = wr_ready_c;
  assign spi_cs_n  = cs_n_q;

  // R3
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (!spi_sclk && eng_idle));
  // R11
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  // R5
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs_n);
  // R11
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && cmd_ready));
  // R6
  chunk_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_PLAN && step == ST_MAIN && code_q == CMD_PROG) |->
      (chunk != '0 && (int'(addr_q[PG_W-1:0]) + int'(chunk)) <= PAGE_BYTES));
endmodule

// File: tb/sflash_sequencer_tb.sv
`timescale 1ns/1ps
module sflash_sequencer_tb;
  localparam int CLK_DIV = 4;
  localparam int SECT = 512;
  localparam logic [7:0] FLASH_ID = 8'h12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_code = '0;
  logic [23:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic busy, done, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  sflash_sequencer #(.CLK_DIV(CLK_DIV), .PAGE_BYTES(256), .SECTOR_BYTES(SECT), .LEN_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, failures = 0, done_cnt = 0, sclk_bad = 0;
  bit finished = 0, rd_thr = 0;

  function automatic logic [7:0] brev(input logic [7:0] b);
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard queues
  logic [15:0] exp_frm[$];   // {opcode, byte count}
  logic [7:0]  exp_rd[$];
  logic [7:0]  wr_src[$];

  // ---------------- flash model
  logic [7:0]  fmem[0:4095];
  logic [7:0]  f_op = '0, in_sh = '0, out_sh = '0, pend = '0, wsr_byte = '0;
  int          f_nb = 0, bitc = 0, busy_left = 0;
  logic [23:0] f_addr = '0, last_addr = '0;
  logic [5:0]  prot = '0;
  bit          wel = 0, op_wel = 0, frame_open = 0;
  realtime     last_rise = 0;

  function automatic logic [7:0] fstat();
    return {prot, wel, (busy_left != 0)};
  endfunction

  always @(negedge spi_cs_n) if (rst_n) begin
    frame_open = 1; f_nb = 0; bitc = 0; pend = 8'h00; out_sh = 8'h00; spi_miso = 1'b0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (bitc != 0 && ($realtime - last_rise) != CLK_DIV * 8) sclk_bad++;
    last_rise = $realtime;
    in_sh = {in_sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      pend = 8'h00;
      if (f_nb == 0) begin
        f_op = in_sh;
        op_wel = wel;
        if (in_sh == 8'h06) wel = 1;
        if (in_sh == 8'h05) pend = fstat();
      end else begin
        if (f_nb <= 3) f_addr = {f_addr[15:0], in_sh};
        if (f_nb == 3) last_addr = f_addr;
        case (f_op)
          8'h05: pend = fstat();
          8'h03: if (f_nb >= 3) begin pend = fmem[f_addr[11:0]]; f_addr = f_addr + 1; end
          8'h02: if (f_nb >= 4) begin
            if (op_wel) fmem[f_addr[11:0]] = in_sh;
            f_addr = {f_addr[23:8], f_addr[7:0] + 8'd1};
          end
          8'h01: if (f_nb == 1) wsr_byte = in_sh;
          8'hAB: if (f_nb >= 3) pend = FLASH_ID;
          default: ;
        endcase
      end
      f_nb++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (bitc == 0) out_sh = pend;
    spi_miso = out_sh[7];
    out_sh = {out_sh[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (frame_open) begin
    frame_open = 0;
    chk(bitc == 0, "R3 whole bytes at cs release", bitc, 0);
    if (exp_frm.size() == 0) chk(0, "R11 unexpected frame", {f_op, 8'(f_nb)}, 0);
    else begin
      logic [15:0] e;
      e = exp_frm.pop_front();
      chk(e == {f_op, 8'(f_nb)}, "R4 frame opcode/bytes", {f_op, 8'(f_nb)}, e);
    end
    if (f_op == 8'h05 && busy_left > 0) busy_left--;
    if ((f_op == 8'h02 || f_op == 8'hD8 || f_op == 8'h01) && op_wel) begin
      busy_left = 3; wel = 0;
      if (f_op == 8'hD8)
        for (int i = 0; i < SECT; i++) fmem[(f_addr[11:0] & 12'(~(SECT - 1))) + 12'(i)] = 8'hFF;
      if (f_op == 8'h01) prot = wsr_byte[7:2];
    end
  end

  // ---------------- stream drivers and monitors
  int tick = 0;
  always @(posedge clk) begin
    tick++;
    rd_ready <= rd_thr ? (tick % 3 == 0) : 1'b1;
    if (wr_valid && wr_ready) void'(wr_src.pop_front());
    wr_valid <= (wr_src.size() > 0);
    wr_data  <= (wr_src.size() > 0) ? wr_src[0] : 8'h00;
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (rd_valid && rd_ready) begin
      if (exp_rd.size() == 0) chk(0, "R5 unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        chk(rd_data == e, "R5/R10 read stream byte", rd_data, e);
      end
    end
  end

  // ---------------- expectation helpers
  task automatic push_poll();
    for (int i = 0; i < 4; i++) exp_frm.push_back({8'h05, 8'd2});
  endtask

  task automatic expect_prog(input int a, input int n);
    while (n > 0) begin
      int room, c;
      room = 256 - (a % 256);
      c = (n < room) ? n : room;
      exp_frm.push_back({8'h06, 8'd1});
      exp_frm.push_back({8'h02, 8'(4 + c)});
      push_poll();
      a += c; n -= c;
    end
  endtask

  task automatic expect_wrsr();
    exp_frm.push_back({8'h05, 8'd2});
    exp_frm.push_back({8'h06, 8'd1});
    exp_frm.push_back({8'h01, 8'd2});
    push_poll();
  endtask

  task automatic issue(input logic [2:0] c, input logic [23:0] a, input logic [15:0] n);
    @(negedge clk);
    cmd_code = c; cmd_addr = a; cmd_len = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy one cycle after accept", busy, 1);
  endtask

  task automatic wait_done(input string tag);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R11 busy low after done", busy, 0);
    repeat (4) @(negedge clk);
    chk(exp_frm.size() == 0, {tag, " frames outstanding"}, exp_frm.size(), 0);
    chk(exp_rd.size() == 0, {tag, " read bytes outstanding"}, exp_rd.size(), 0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- main sequence
  initial begin
    int d0;
    for (int i = 0; i < 4096; i++) fmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(cmd_ready == 1'b1 && rd_valid == 1'b0, "R1 ready/rd_valid", {cmd_ready, rd_valid}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 read ID: opcode + 3 dummy + ID
    exp_frm.push_back({8'hAB, 8'd5});
    exp_rd.push_back(FLASH_ID);
    issue(3'd5, 24'h0, 16'd0);
    wait_done("R10 id");
    chk(last_addr == 24'h0, "R10 dummy bytes zero", last_addr, 0);

    // R10 read status, initial 0x00
    exp_frm.push_back({8'h05, 8'd2});
    exp_rd.push_back(8'h00);
    issue(3'd3, 24'h0, 16'd0);
    wait_done("R10 status");

    // R9 set mask 0x1C then clear mask 0x0C
    expect_wrsr();
    issue(3'd4, 24'h00001C, 16'd0);
    wait_done("R9 set");
    chk(wsr_byte == 8'h1C, "R9 status byte written", wsr_byte, 8'h1C);
    exp_frm.push_back({8'h05, 8'd2});
    exp_rd.push_back(8'h1C);
    issue(3'd3, 24'h0, 16'd0);
    wait_done("R9 readback");
    expect_wrsr();
    issue(3'd4, 24'h000C00, 16'd0);
    wait_done("R9 clear");
    chk(wsr_byte == 8'h10, "R9 read-modify-write result", wsr_byte, 8'h10);

    // R5 read with throttled rd_ready, crossing a page in one frame
    rd_thr = 1;
    exp_frm.push_back({8'h03, 8'd20});
    for (int i = 0; i < 16; i++) exp_rd.push_back(brev(fmem[12'h7F8 + 12'(i)]));
    issue(3'd0, 24'h0007F8, 16'd16);
    wait_done("R5 read");
    chk(last_addr == 24'h0007F8, "R4 address MSB first", last_addr, 24'h7F8);
    rd_thr = 0;

    // R6 R7 program crossing a page boundary
    expect_prog(24'hF0, 32);
    for (int i = 0; i < 32; i++) wr_src.push_back(8'(8'h80 + i * 3));
    issue(3'd1, 24'h0000F0, 16'd32);
    wait_done("R6 prog");
    for (int i = 0; i < 32; i += 7)
      chk(fmem[12'hF0 + 12'(i)] == brev(8'(8'h80 + i * 3)), "R6 programmed bits reversed",
          fmem[12'hF0 + 12'(i)], brev(8'(8'h80 + i * 3)));
    exp_frm.push_back({8'h03, 8'd36});
    for (int i = 0; i < 32; i++) exp_rd.push_back(8'(8'h80 + i * 3));
    issue(3'd0, 24'h0000F0, 16'd32);
    wait_done("R5 readback");

    // R8 erase sector 1
    exp_frm.push_back({8'h06, 8'd1});
    exp_frm.push_back({8'hD8, 8'd4});
    push_poll();
    issue(3'd2, 24'd1, 16'd0);
    wait_done("R8 erase");
    chk(last_addr == 24'h000200, "R8 sector address", last_addr, 24'h200);
    exp_frm.push_back({8'h03, 8'd8});
    exp_rd.push_back(8'hFF); exp_rd.push_back(8'hFF);
    exp_rd.push_back(brev(fmem[12'h400])); exp_rd.push_back(brev(fmem[12'h401]));
    issue(3'd0, 24'h0003FE, 16'd4);
    wait_done("R8 erase extent");

    // R11 commands while busy are ignored
    d0 = done_cnt;
    expect_prog(24'h10, 4);
    for (int i = 0; i < 4; i++) wr_src.push_back(8'(i + 1));
    issue(3'd1, 24'h000010, 16'd4);
    repeat (30) @(negedge clk);
    cmd_code = 3'd0; cmd_addr = 24'h0; cmd_len = 16'd4; cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk(cmd_ready == 1'b0, "R11 not ready while busy", cmd_ready, 0);
    cmd_valid = 1'b0;
    wait_done("R11 busy ignore");
    repeat (400) @(negedge clk);
    chk(done_cnt == d0 + 1, "R11 single done", done_cnt - d0, 1);

    // R12 zero-length program and unused code: no frame, done two cycles after accept
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cmd_code = (k == 0) ? 3'd1 : 3'd7; cmd_addr = 24'h0; cmd_len = 16'd0; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy && !done, "R12 accept cycle", {busy, done}, 2);
      @(negedge clk);
      chk(done == 1'b1, "R12 done pulse", done, 1);
      @(negedge clk);
      chk(!busy && !done, "R12 idle again", {busy, done}, 0);
      chk(spi_cs_n == 1'b1, "R12 no frame", spi_cs_n, 1);
    end

    chk(sclk_bad == 0, "R2 sclk period", sclk_bad, 0);
    repeat (20) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule